// File: doc/BRIEF.md
# Gated Retriggerable One-Shot Timer

This block is a clocked pulse stretcher. Four gate inputs control it: two active-low gates and two active-high gates. An active-low clear sits above them and overrides both. The gates combine into one enable term. Each time that term goes from false to true, the block drives `q` high for a programmed number of clock cycles. A fresh edge during a pulse restarts the full length, so a steady stream of edges can hold `q` high indefinitely. A holdoff counter makes edges that come too soon after the last accepted one count for nothing.

Each gate input passes through a stability filter before it reaches the edge detector. A new level counts only after it has been seen on `STABLE_N` consecutive clock samples. The clear input bypasses the filter, so it takes effect at once. The pulse length and the holdoff length are captured from `width_cfg` and `hold_cfg` while reset is asserted.

Typical uses are a watchdog-style activity detector, a missing-pulse detector, or an output stretcher driven by logic of either polarity.

Top module: `retrig_oneshot`

## Requirements
- R1: The enable term is true when at least one bit of `gate_lo_n` is 0, both bits of `gate_hi` are 1, and `clr_n` is 1. When a rising edge of this term is accepted at a clock edge, `q` is high for exactly the captured width in cycles, starting right after that edge, unless a clear or a retrigger intervenes. An enable term that stays high does not fire again.
- R2: A falling `gate_lo_n` bit fires a pulse while both `gate_hi` bits are 1. It fires `STABLE_N`+1 clock edges after the input changes.
- R3: A rising `gate_hi` bit fires a pulse while some `gate_lo_n` bit is 0. It fires `STABLE_N`+1 edges after the input changes.
- R4: When `clr_n` rises while the filtered gates already satisfy the enable term, a pulse fires at the very next clock edge.
- R5: While `clr_n` is 0, `q` is 0 and `q_n` is 1 at once, with no clock needed. A pulse cut short this way does not resume when `clr_n` returns to 1.
- R6: The output stays at rest while both `gate_lo_n` bits are 1 or while any `gate_hi` bit is 0, whatever the other inputs do.
- R7: An edge of the enable term that comes during a pulse, once the holdoff has run out, reloads the full width from that edge.
- R8: An edge that comes during a pulse while fewer than the captured holdoff cycles have passed since the last accepted edge has no effect. The pulse still ends at its original time.
- R9: `q_n` is always the complement of `q`.
- R10: A gate input change that lasts fewer than `STABLE_N` samples is ignored.
- R11: A captured width of 0 suppresses all output pulses.
- R12: After reset `q` is 0. An enable term that is already satisfied when reset is released does not fire a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high; captures the configuration |
| gate_lo_n | input | 2 | Active-low gate inputs |
| gate_hi | input | 2 | Active-high gate inputs |
| clr_n | input | 1 | Overriding clear, active low, unfiltered |
| width_cfg | input | WIDTH_W | Pulse length in cycles, captured during reset |
| hold_cfg | input | HOLD_W | Retrigger holdoff in cycles, captured during reset |
| q | output | 1 | Pulse output |
| q_n | output | 1 | Complement of `q` |

## Verification
The hardest case to reach is a retrigger that lands inside the holdoff window. To produce a second edge, the enable term must first fall and then rise again, and each of those changes has to pass the stability filter. Even a tight bounce of one `gate_hi` bit therefore takes 2·`STABLE_N`+1 cycles to produce its edge. The directed sequence starts that bounce on the first cycle of a pulse, with a holdoff configured just longer than the bounce latency. It then repeats the bounce after the holdoff has expired, so that the ignored edge and the accepted edge can be told apart from the pulse end times alone.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

    // gates per polarity
    localparam int N_GATE = 2;

    // timer state as seen from outside the counter
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_LOCKED = 2'd1,
        PH_OPEN   = 2'd2
    } phase_e;

    // combined enable term of the gate inputs
    function automatic logic gate_open(
        input logic [N_GATE-1:0] lo_n,
        input logic [N_GATE-1:0] hi,
        input logic              clr_n
    );
        return (~&lo_n) & (&hi) & clr_n;
    endfunction

endpackage

// File: rtl/os_input_filter.sv
module os_input_filter #(
    parameter int STABLE_N = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    output logic lvl
);
    localparam int            CW   = $clog2(STABLE_N + 1);
    localparam logic [CW-1:0] LAST = CW'(STABLE_N - 1);

    typedef struct packed {
        logic          lvl;
        logic [CW-1:0] run;
    } flt_t;

    flt_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (rst) begin
            r_d.lvl = raw;
            r_d.run = '0;
        end else if (raw == r_q.lvl) begin
            r_d.run = '0;
        end else if (r_q.run == LAST) begin
            r_d.lvl = raw;
            r_d.run = '0;
        end else begin
            r_d.run = r_q.run + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    assign lvl = r_q.lvl;

endmodule

// File: rtl/os_gate_detect.sv
module os_gate_detect
    import oneshot_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [N_GATE-1:0] raw_lo_n,
    input  logic [N_GATE-1:0] raw_hi,
    input  logic [N_GATE-1:0] filt_lo_n,
    input  logic [N_GATE-1:0] filt_hi,
    input  logic              clr_n,
    output logic              trig
);
    typedef struct packed {
        logic prev;
    } det_t;

    det_t r_d, r_q;
    logic open_now;

    always_comb begin
        open_now = gate_open(filt_lo_n, filt_hi, clr_n);
        r_d      = r_q;
        if (rst) begin
            // seed from the live inputs so release cannot look like an edge
            r_d.prev = gate_open(raw_lo_n, raw_hi, clr_n);
        end else begin
            r_d.prev = open_now;
        end
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    assign trig = ~rst & open_now & ~r_q.prev;

endmodule

// File: rtl/os_pulse_timer.sv
module os_pulse_timer
    import oneshot_pkg::*;
#(
    parameter int WIDTH_W = 16,
    parameter int HOLD_W  = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr_n,
    input  logic               trig,
    input  logic [WIDTH_W-1:0] width_cfg,
    input  logic [HOLD_W-1:0]  hold_cfg,
    output phase_e             phase
);
    typedef struct packed {
        logic [WIDTH_W-1:0] width;
        logic [HOLD_W-1:0]  hold_len;
        logic [WIDTH_W-1:0] cnt;
        logic [HOLD_W-1:0]  hold;
    } tmr_t;

    tmr_t   r_d, r_q;
    phase_e ph;

    always_comb begin
        if (r_q.cnt == '0) begin
            ph = PH_IDLE;
        end else if (r_q.hold != '0) begin
            ph = PH_LOCKED;
        end else begin
            ph = PH_OPEN;
        end
    end

    always_comb begin
        r_d = r_q;
        if (rst) begin
            r_d.width    = width_cfg;
            r_d.hold_len = hold_cfg;
            r_d.cnt      = '0;
            r_d.hold     = '0;
        end else if (!clr_n) begin
            r_d.cnt  = '0;
            r_d.hold = '0;
        end else if (trig && ph != PH_LOCKED) begin
            r_d.cnt  = r_q.width;
            r_d.hold = r_q.hold_len;
        end else begin
            if (r_q.cnt != '0) begin
                r_d.cnt = r_q.cnt - WIDTH_W'(1);
            end
            if (r_q.hold != '0) begin
                r_d.hold = r_q.hold - HOLD_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    assign phase = ph;

endmodule

// File: rtl/retrig_oneshot.sv
module retrig_oneshot
    import oneshot_pkg::*;
#(
    parameter int WIDTH_W  = 16,
    parameter int HOLD_W   = 8,
    parameter int STABLE_N = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [1:0]         gate_lo_n,
    input  logic [1:0]         gate_hi,
    input  logic               clr_n,
    input  logic [WIDTH_W-1:0] width_cfg,
    input  logic [HOLD_W-1:0]  hold_cfg,
    output logic               q,
    output logic               q_n
);
    localparam int N_IN = 2 * N_GATE;

    logic [N_IN-1:0] raw_in;
    logic [N_IN-1:0] filt_in;
    logic            trig;
    phase_e          phase;

    assign raw_in = {gate_hi, gate_lo_n};

    for (genvar g = 0; g < N_IN; g++) begin : g_flt
        os_input_filter #(
            .STABLE_N (STABLE_N)
        ) u_flt (
            .clk (clk),
            .rst (rst),
            .raw (raw_in[g]),
            .lvl (filt_in[g])
        );
    end

    os_gate_detect u_det (
        .clk       (clk),
        .rst       (rst),
        .raw_lo_n  (gate_lo_n),
        .raw_hi    (gate_hi),
        .filt_lo_n (filt_in[N_GATE-1:0]),
        .filt_hi   (filt_in[N_IN-1:N_GATE]),
        .clr_n     (clr_n),
        .trig      (trig)
    );

    os_pulse_timer #(
        .WIDTH_W (WIDTH_W),
        .HOLD_W  (HOLD_W)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .clr_n     (clr_n),
        .trig      (trig),
        .width_cfg (width_cfg),
        .hold_cfg  (hold_cfg),
        .phase     (phase)
    );

    assign q   = (phase != PH_IDLE) & clr_n;
    assign q_n = ~q;

endmodule

// File: rtl/retrig_oneshot_chk.sv
module retrig_oneshot_chk
    import oneshot_pkg::*;
#(
    parameter int WIDTH_W = 16
) (
    input logic                clk,
    input logic                rst,
    input logic                clr_n,
    input logic                q,
    input logic                q_n,
    input logic                trig,
    input phase_e              phase,
    input logic [WIDTH_W-1:0]  cnt,
    input logic [WIDTH_W-1:0]  width,
    input logic [2*N_GATE-1:0] filt
);

    p_clear_forces_low_r5: assert property (@(posedge clk) disable iff (rst)
        !clr_n |-> (!q && q_n));

    p_clear_empties_r5: assert property (@(posedge clk) disable iff (rst)
        !clr_n |=> (phase == PH_IDLE));

    p_rise_from_trigger_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(q) |-> $past(trig));

    p_inactive_no_trig_r6: assert property (@(posedge clk) disable iff (rst)
        ((&filt[N_GATE-1:0]) || !(&filt[2*N_GATE-1:N_GATE])) |-> !trig);

    p_retrigger_reload_r7: assert property (@(posedge clk) disable iff (rst)
        (trig && phase != PH_LOCKED) |=> (cnt == width));

    p_holdoff_ignore_r8: assert property (@(posedge clk) disable iff (rst)
        (trig && phase == PH_LOCKED) |=> (cnt == $past(cnt) - WIDTH_W'(1)));

    p_zero_width_r11: assert property (@(posedge clk) disable iff (rst)
        (width == '0) |-> !q);

endmodule

bind retrig_oneshot retrig_oneshot_chk #(
    .WIDTH_W (WIDTH_W)
) u_chk (
    .clk   (clk),
    .rst   (rst),
    .clr_n (clr_n),
    .q     (q),
    .q_n   (q_n),
    .trig  (trig),
    .phase (phase),
    .cnt   (u_timer.r_q.cnt),
    .width (u_timer.r_q.width),
    .filt  (filt_in)
);

// File: tb/sim_retrig_oneshot.sv
`timescale 1ns/1ps
module sim_retrig_oneshot;
    localparam int W_W = 8;
    localparam int H_W = 8;
    localparam int SN  = 2;
    localparam int L   = SN + 1;
    localparam int WID = 12;
    localparam int HLD = 6;

    logic           clk = 1'b0;
    logic           rst;
    logic [1:0]     a, b;
    logic           clr;
    logic [W_W-1:0] wcfg;
    logic [H_W-1:0] hcfg;
    logic           q, q_n;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // reference state
    logic [1:0] mfa, mfb;
    int         mrun [4];
    bit         mprev;
    int         mcnt, mhold, mW, mH;

    retrig_oneshot #(.WIDTH_W(W_W), .HOLD_W(H_W), .STABLE_N(SN)) u0 (
        .clk(clk), .rst(rst), .gate_lo_n(a), .gate_hi(b), .clr_n(clr),
        .width_cfg(wcfg), .hold_cfg(hcfg), .q(q), .q_n(q_n)
    );

    always #4 clk = ~clk;

    function automatic bit en_of(logic [1:0] lo, logic [1:0] hi, logic c);
        return (lo != 2'b11) && (hi == 2'b11) && c;
    endfunction

    task automatic model_step();
        bit e, t, raw, cur;
        if (rst) begin
            mfa = a; mfb = b;
            for (int i = 0; i < 4; i++) mrun[i] = 0;
            mprev = en_of(a, b, clr);
            mcnt = 0; mhold = 0; mW = int'(wcfg); mH = int'(hcfg);
        end else begin
            e = en_of(mfa, mfb, clr);
            t = e && !mprev;
            mprev = e;
            if (!clr) begin
                mcnt = 0; mhold = 0;
            end else if (t && (mcnt == 0 || mhold == 0)) begin
                mcnt = mW; mhold = mH;
            end else begin
                if (mcnt > 0) mcnt--;
                if (mhold > 0) mhold--;
            end
            for (int i = 0; i < 4; i++) begin
                raw = (i < 2) ? a[i] : b[i-2];
                cur = (i < 2) ? mfa[i] : mfb[i-2];
                if (raw == cur) mrun[i] = 0;
                else if (mrun[i] == SN - 1) begin
                    mrun[i] = 0;
                    if (i < 2) mfa[i] = raw; else mfb[i-2] = raw;
                end else mrun[i]++;
            end
        end
    endtask

    task automatic chk(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic check_out(string tag);
        bit e;
        e = (mcnt != 0) && clr;
        chk(q === e, tag, int'(q), int'(e));
        chk(q_n === ~q, "R9", int'(q_n), int'(!q));
    endtask

    task automatic expect_q(bit e, string tag);
        chk(q === e, tag, int'(q), int'(e));
    endtask

    task automatic clk_n(int n, string tag);
        repeat (n) begin
            @(posedge clk);
            model_step();
            @(negedge clk);
            check_out(tag);
        end
    endtask

    task automatic set_in(logic [1:0] aa, logic [1:0] bb, logic cc, string tag);
        a = aa; b = bb; clr = cc;
        #1;
        check_out(tag);
    endtask

    task automatic do_reset(int w, int h);
        rst = 1'b1; wcfg = W_W'(w); hcfg = H_W'(h);
        repeat (2) begin
            @(posedge clk);
            model_step();
        end
        @(negedge clk);
        rst = 1'b0;
        #1;
        expect_q(1'b0, "R12");
        check_out("R12");
    endtask

    initial begin
        #(8ns * 200000);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [1:0] na, nb;
        logic       nc;
        int         w;
        void'($urandom(32'h0511_5eed));
        a = 2'b11; b = 2'b11; clr = 1'b1; rst = 1'b1;
        wcfg = W_W'(WID); hcfg = H_W'(HLD);
        @(negedge clk);
        do_reset(WID, HLD);

        // R2: falling low-active gate
        set_in(2'b10, 2'b11, 1'b1, "R2");
        clk_n(L, "R2");        expect_q(1'b1, "R2");
        clk_n(WID - 1, "R1");  expect_q(1'b1, "R1");
        clk_n(1, "R1");        expect_q(1'b0, "R1");
        clk_n(3, "R1");        expect_q(1'b0, "R1");

        // R6: inactive levels hold the output at rest
        set_in(2'b11, 2'b11, 1'b1, "R6"); clk_n(L + 1, "R6");
        set_in(2'b11, 2'b10, 1'b1, "R6"); clk_n(L + 1, "R6");
        set_in(2'b11, 2'b11, 1'b1, "R6"); clk_n(L + 1, "R6");
        expect_q(1'b0, "R6");
        set_in(2'b01, 2'b10, 1'b1, "R6"); clk_n(L + 1, "R6");
        expect_q(1'b0, "R6");

        // R3: rising high-active gate
        set_in(2'b01, 2'b11, 1'b1, "R3");
        clk_n(L, "R3");        expect_q(1'b1, "R3");
        clk_n(WID, "R3");      expect_q(1'b0, "R1");

        // R4: clear release with gate already open
        set_in(2'b01, 2'b11, 1'b0, "R5"); clk_n(3, "R5");
        set_in(2'b01, 2'b11, 1'b1, "R4"); expect_q(1'b0, "R4");
        clk_n(1, "R4");        expect_q(1'b1, "R4");
        clk_n(WID - 1, "R4");  expect_q(1'b1, "R4");
        clk_n(1, "R4");        expect_q(1'b0, "R4");

        // R5: clear aborts and the pulse does not resume
        set_in(2'b01, 2'b11, 1'b0, "R5"); clk_n(1, "R5");
        set_in(2'b01, 2'b11, 1'b1, "R5"); clk_n(3, "R5");
        expect_q(1'b1, "R5");
        set_in(2'b01, 2'b10, 1'b0, "R5"); expect_q(1'b0, "R5");
        chk(q_n === 1'b1, "R5", int'(q_n), 1);
        clk_n(2, "R5");        expect_q(1'b0, "R5");
        set_in(2'b01, 2'b10, 1'b1, "R5"); clk_n(L + 2, "R5");
        expect_q(1'b0, "R5");

        // R8: bounce inside holdoff is ignored
        set_in(2'b01, 2'b11, 1'b1, "R8"); clk_n(L, "R8");
        expect_q(1'b1, "R8");
        set_in(2'b01, 2'b10, 1'b1, "R8"); clk_n(SN, "R8");
        set_in(2'b01, 2'b11, 1'b1, "R8"); clk_n(SN + 1, "R8");
        expect_q(1'b1, "R8");
        clk_n(WID - (2 * SN + 1) - 1, "R8"); expect_q(1'b1, "R8");
        clk_n(1, "R8");        expect_q(1'b0, "R8");

        // R7: bounce after holdoff restarts the full width
        set_in(2'b01, 2'b10, 1'b1, "R7"); clk_n(SN, "R7");
        set_in(2'b01, 2'b11, 1'b1, "R7"); clk_n(SN + 1, "R7");
        expect_q(1'b1, "R7");
        clk_n(6, "R7");
        set_in(2'b01, 2'b10, 1'b1, "R7"); clk_n(SN, "R7");
        set_in(2'b01, 2'b11, 1'b1, "R7"); clk_n(SN + 1, "R7");
        expect_q(1'b1, "R7");
        clk_n(1, "R7");        expect_q(1'b1, "R7");
        clk_n(WID - 2, "R7");  expect_q(1'b1, "R7");
        clk_n(1, "R7");        expect_q(1'b0, "R7");

        // R10: short glitches are ignored
        set_in(2'b11, 2'b11, 1'b1, "R10"); clk_n(L + 1, "R10");
        set_in(2'b10, 2'b11, 1'b1, "R10"); clk_n(SN - 1, "R10");
        set_in(2'b11, 2'b11, 1'b1, "R10"); clk_n(L + 3, "R10");
        expect_q(1'b0, "R10");
        set_in(2'b01, 2'b10, 1'b1, "R10"); clk_n(L + 1, "R10");
        set_in(2'b01, 2'b11, 1'b1, "R10"); clk_n(SN - 1, "R10");
        set_in(2'b01, 2'b10, 1'b1, "R10"); clk_n(L + 3, "R10");
        expect_q(1'b0, "R10");
        set_in(2'b01, 2'b11, 1'b1, "R10"); clk_n(SN, "R10");
        expect_q(1'b0, "R10");
        clk_n(1, "R10");       expect_q(1'b1, "R10");
        clk_n(WID, "R10");

        // R12: reset released with gate open
        do_reset(WID, HLD);
        clk_n(5, "R12");       expect_q(1'b0, "R12");

        // R11: zero width
        do_reset(0, 0);
        set_in(2'b01, 2'b10, 1'b1, "R11"); clk_n(SN, "R11");
        set_in(2'b01, 2'b11, 1'b1, "R11"); clk_n(SN + 1, "R11");
        expect_q(1'b0, "R11");
        set_in(2'b01, 2'b11, 1'b0, "R11"); clk_n(1, "R11");
        set_in(2'b01, 2'b11, 1'b1, "R11"); clk_n(1, "R11");
        expect_q(1'b0, "R11");

        // random traffic against the reference
        for (int blk = 0; blk < 4; blk++) begin
            w = 4 + int'($urandom % 17);
            do_reset(w, int'($urandom % (w - 1)));
            for (int i = 0; i < 1000; i++) begin
                na = a; nb = b; nc = clr;
                if ($urandom % 6 == 0) na[$urandom % 2] = ~na[$urandom % 2];
                if ($urandom % 7 == 0) nb[$urandom % 2] = ~nb[$urandom % 2];
                if (nc && ($urandom % 50 == 0)) nc = 1'b0;
                else if (!nc && ($urandom % 4 == 0)) nc = 1'b1;
                set_in(na, nb, nc, "R1");
                clk_n(1, "R1");
            end
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule